// File: doc/BRIEF.md
# Multiplexed DRAM Address-Line and Cell Tester

This block drives a single-bit-wide dynamic RAM whose row and column addresses share one bus. It produces the row and column strobes, the write enable and the write data itself. It also keeps every row alive with RAS-only refresh while a self-test loop runs without end. Each loop first checks every address wire of the combined row/column address. It then runs a data-pattern test over the whole array. That test places one set bit in every group of locations, moves it through all positions in the group, and follows each position with its complement.

One output lamp reports the result. The lamp is lit while testing. It goes dark for a short fixed time at the end of each clean loop. It goes dark for good at the first wrong read. The array geometry, the pattern group size, every strobe phase length, the read-sample point, the refresh interval and the blink length are parameters. The defaults give a 256 x 256 array with one row refreshed every 15.6 us at 100 MHz.

Top module: `dram_tester`

## Requirements
- R1: Location L (2*RA_BITS bits) is sent as row = upper RA_BITS bits, then column = lower RA_BITS bits. The bus holds the row for the cycle before RAS falls and while RAS is low until the column phase. It holds the column from the cycle before CAS falls until CAS rises.
- R2: An access is: row setup for T_ASR clocks, RAS low for T_RCD clocks, column setup for T_ASC clocks, CAS low for exactly T_CAS clocks, then both strobes high for T_RP clocks. Write enable (low = write) and write data are valid from the column phase onward. Read data is captured T_CAC clocks after CAS falls.
- R3: Refresh is RAS-only. RAS is low for exactly T_RAS clocks with no CAS, and the row comes from a counter that advances by one per refresh. One refresh falls due every REF_CLKS clocks, so every row is strobed at least once per ROWS*REF_CLKS clocks plus one access.
- R4: A refresh that is due is started before the next test access. Consecutive refreshes are never more than REF_CLKS plus one access length apart.
- R5: The address test runs for each bit b from 0 to 2*RA_BITS-1 in ascending order. For each bit it writes 0 to location 0, then writes 1 to location 2^b, then reads location 0.
- R6: A 1 read back from location 0 during the address test is a failure. The cell test is not started.
- R7: The cell test makes 2*PAT_W passes, where PAT_W = 2^PAT_LOG. The passes take shift s = 0 to PAT_W-1 in order, and each s is run as the plain pass followed by the inverted pass. The value at location L is (L mod PAT_W == s) XOR inverted. Each pass writes all locations in ascending order, then reads them all in ascending order. One full loop therefore makes 2*AW + 2*PAT_W*N writes and AW + 2*PAT_W*N reads, where AW = 2*RA_BITS and N = 2^AW.
- R8: Any cell-test read that differs from the value written is a failure.
- R9: The lamp (1 = lit) is lit while testing. After a clean loop it is dark for exactly BLINK_CLKS clocks. A new loop then starts with the address test.
- R10: After a failure the lamp stays dark until reset. No further CAS cycle occurs, and refresh continues.
- R11: During reset both strobes and write enable are high (inactive) and the lamp is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dram_addr | output | RA_BITS | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_wdata | output | 1 | Data bit to the memory |
| dram_rdata | input | 1 | Data bit from the memory |
| led | output | 1 | Status lamp, 1 = lit |

## Verification
The properties assume that the memory returns the stored bit on dram_rdata by the capture point. They also assume that the lamp goes dark for longer than BLINK_CLKS only after a failure. The bench models the memory on the falling clock edge. It drives the complement of the stored bit until T_CAC-1 falling edges after CAS falls, so a capture that comes too early reads a wrong bit. Faults are injected only as an address bit stuck low or a single cell stuck high, both set up before reset is released. The bench therefore never changes memory contents while a strobe is low.

// File: rtl/dram_tester_pkg.sv
`timescale 1ns/1ps
package dram_tester_pkg;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'd0,
    OP_READ    = 2'd1,
    OP_REFRESH = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ROW  = 3'd1,
    PH_RAS  = 3'd2,
    PH_COL  = 3'd3,
    PH_CAS  = 3'd4,
    PH_PRE  = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    TS_AZERO = 3'd0,
    TS_AONE  = 3'd1,
    TS_ACHK  = 3'd2,
    TS_CWR   = 3'd3,
    TS_CRD   = 3'd4,
    TS_BLINK = 3'd5,
    TS_FAIL  = 3'd6
  } tstate_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_strobe_seq.sv
`timescale 1ns/1ps
module dram_strobe_seq
  import dram_tester_pkg::*;
#(
  parameter int RA_BITS = 8,
  parameter int T_ASR   = 1,
  parameter int T_RCD   = 3,
  parameter int T_ASC   = 1,
  parameter int T_CAS   = 4,
  parameter int T_CAC   = 3,
  parameter int T_RAS   = 10,
  parameter int T_RP    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  op_e                op,
  input  logic [RA_BITS-1:0] row,
  input  logic [RA_BITS-1:0] col,
  input  logic               wdata,
  output logic               idle,
  output logic               done,
  output logic               rdata,
  output logic [RA_BITS-1:0] pin_addr,
  output logic               pin_ras_n,
  output logic               pin_cas_n,
  output logic               pin_we_n,
  output logic               pin_wdata,
  input  logic               pin_rdata
);

  localparam int TMAX = imax(imax(imax(T_ASR, T_RCD), imax(T_ASC, T_CAS)),
                             imax(imax(T_RAS, T_RP), T_CAC));
  localparam int CW   = $clog2(TMAX + 1);

  phase_e             ph_q, ph_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  op_e                op_q, op_d;
  logic [RA_BITS-1:0] row_q, row_d, col_q, col_d;
  logic               wd_q, wd_d;
  logic               rd_q, rd_d;
  logic               done_q, done_d;
  logic               last;
  logic               ras_last;

  always_comb begin
    ras_last = (op_q == OP_REFRESH) ? (cnt_q == CW'(T_RAS - 1))
                                    : (cnt_q == CW'(T_RCD - 1));
    case (ph_q)
      PH_ROW:  last = (cnt_q == CW'(T_ASR - 1));
      PH_RAS:  last = ras_last;
      PH_COL:  last = (cnt_q == CW'(T_ASC - 1));
      PH_CAS:  last = (cnt_q == CW'(T_CAS - 1));
      PH_PRE:  last = (cnt_q == CW'(T_RP - 1));
      default: last = 1'b0;
    endcase
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = last ? '0 : cnt_q + CW'(1);
    op_d   = op_q;
    row_d  = row_q;
    col_d  = col_q;
    wd_d   = wd_q;
    rd_d   = rd_q;
    done_d = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) begin
          ph_d  = PH_ROW;
          op_d  = op;
          row_d = row;
          col_d = col;
          wd_d  = wdata;
        end
      end
      PH_ROW: if (last) ph_d = PH_RAS;
      PH_RAS: if (last) ph_d = (op_q == OP_REFRESH) ? PH_PRE : PH_COL;
      PH_COL: if (last) ph_d = PH_CAS;
      PH_CAS: begin
        if (op_q == OP_READ && cnt_q == CW'(T_CAC - 1)) rd_d = pin_rdata;
        if (last) ph_d = PH_PRE;
      end
      PH_PRE: begin
        if (last) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      op_q   <= OP_READ;
      row_q  <= '0;
      col_q  <= '0;
      wd_q   <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      row_q  <= row_d;
      col_q  <= col_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    pin_ras_n = !(ph_q == PH_RAS || ph_q == PH_COL || ph_q == PH_CAS);
    pin_cas_n = (ph_q != PH_CAS);
    pin_we_n  = !((ph_q == PH_COL || ph_q == PH_CAS) && op_q == OP_WRITE);
    pin_addr  = (ph_q == PH_COL || ph_q == PH_CAS) ? col_q : row_q;
    pin_wdata = wd_q;
    idle      = (ph_q == PH_IDLE);
    done      = done_q;
    rdata     = rd_q;
  end

endmodule

// File: rtl/dram_refresh_timer.sv
`timescale 1ns/1ps
module dram_refresh_timer #(
  parameter int RA_BITS  = 8,
  parameter int REF_CLKS = 1560
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack,
  output logic               pending,
  output logic [RA_BITS-1:0] row
);

  localparam int TW = $clog2(REF_CLKS);

  logic [TW-1:0]      tcnt_q, tcnt_d;
  logic               pend_q, pend_d;
  logic [RA_BITS-1:0] row_q, row_d;
  logic               tick;

  always_comb begin
    tick   = (tcnt_q == TW'(REF_CLKS - 1));
    tcnt_d = tick ? '0 : tcnt_q + TW'(1);
    pend_d = pend_q;
    row_d  = row_q;
    if (ack) begin
      pend_d = 1'b0;
      row_d  = row_q + RA_BITS'(1);
    end
    if (tick) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      pend_q <= pend_d;
      row_q  <= row_d;
    end
  end

  assign pending = pend_q;
  assign row     = row_q;

endmodule

// File: rtl/dram_test_seq.sv
`timescale 1ns/1ps
module dram_test_seq
  import dram_tester_pkg::*;
#(
  parameter int RA_BITS    = 8,
  parameter int PAT_LOG    = 3,
  parameter int BLINK_CLKS = 5000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gnt,
  input  logic               done,
  input  logic               rdata,
  output logic               req,
  output op_e                op,
  output logic [RA_BITS-1:0] row,
  output logic [RA_BITS-1:0] col,
  output logic               wdata,
  output logic               led
);

  localparam int AW  = 2 * RA_BITS;
  localparam int BW  = $clog2(AW);
  localparam int BCW = $clog2(BLINK_CLKS + 1);

  tstate_e         st_q, st_d;
  logic            wait_q, wait_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [PAT_LOG-1:0] shift_q, shift_d;
  logic            inv_q, inv_d;
  logic [BCW-1:0]  bcnt_q, bcnt_d;
  logic [AW-1:0]   loc;
  logic            exp_bit;
  logic            is_op;
  logic            addr_end;

  always_comb begin
    exp_bit  = (addr_q[PAT_LOG-1:0] == shift_q) ^ inv_q;
    addr_end = (addr_q == {AW{1'b1}});
    op       = OP_READ;
    loc      = '0;
    wdata    = 1'b0;
    is_op    = 1'b1;
    case (st_q)
      TS_AZERO: op = OP_WRITE;
      TS_AONE: begin
        op    = OP_WRITE;
        loc   = AW'(1) << bit_q;
        wdata = 1'b1;
      end
      TS_ACHK: op = OP_READ;
      TS_CWR: begin
        op    = OP_WRITE;
        loc   = addr_q;
        wdata = exp_bit;
      end
      TS_CRD: loc = addr_q;
      default: is_op = 1'b0;
    endcase
    row = loc[AW-1:RA_BITS];
    col = loc[RA_BITS-1:0];
    req = is_op && !wait_q;
    led = !(st_q == TS_BLINK || st_q == TS_FAIL);
  end

  always_comb begin
    st_d    = st_q;
    wait_d  = wait_q;
    bit_d   = bit_q;
    addr_d  = addr_q;
    shift_d = shift_q;
    inv_d   = inv_q;
    bcnt_d  = bcnt_q;
    if (req && gnt) wait_d = 1'b1;
    if (wait_q && done) begin
      wait_d = 1'b0;
      case (st_q)
        TS_AZERO: st_d = TS_AONE;
        TS_AONE:  st_d = TS_ACHK;
        TS_ACHK: begin
          if (rdata) st_d = TS_FAIL;
          else if (bit_q == BW'(AW - 1)) begin
            st_d    = TS_CWR;
            addr_d  = '0;
            shift_d = '0;
            inv_d   = 1'b0;
          end else begin
            bit_d = bit_q + BW'(1);
            st_d  = TS_AZERO;
          end
        end
        TS_CWR: begin
          addr_d = addr_q + AW'(1);
          if (addr_end) st_d = TS_CRD;
        end
        TS_CRD: begin
          addr_d = addr_q + AW'(1);
          if (rdata != exp_bit) st_d = TS_FAIL;
          else if (addr_end) begin
            if (!inv_q) begin
              inv_d = 1'b1;
              st_d  = TS_CWR;
            end else if (shift_q == {PAT_LOG{1'b1}}) begin
              st_d   = TS_BLINK;
              bcnt_d = '0;
            end else begin
              shift_d = shift_q + PAT_LOG'(1);
              inv_d   = 1'b0;
              st_d    = TS_CWR;
            end
          end
        end
        default: st_d = st_q;
      endcase
    end
    if (st_q == TS_BLINK) begin
      if (bcnt_q == BCW'(BLINK_CLKS - 1)) begin
        st_d  = TS_AZERO;
        bit_d = '0;
      end else begin
        bcnt_d = bcnt_q + BCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TS_AZERO;
      wait_q  <= 1'b0;
      bit_q   <= '0;
      addr_q  <= '0;
      shift_q <= '0;
      inv_q   <= 1'b0;
      bcnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      wait_q  <= wait_d;
      bit_q   <= bit_d;
      addr_q  <= addr_d;
      shift_q <= shift_d;
      inv_q   <= inv_d;
      bcnt_q  <= bcnt_d;
    end
  end

endmodule

// File: rtl/dram_tester.sv
`timescale 1ns/1ps
module dram_tester
  import dram_tester_pkg::*;
#(
  parameter int RA_BITS    = 8,
  parameter int PAT_LOG    = 3,
  parameter int REF_CLKS   = 1560,
  parameter int BLINK_CLKS = 5000000,
  parameter int T_ASR      = 1,
  parameter int T_RCD      = 3,
  parameter int T_ASC      = 1,
  parameter int T_CAS      = 4,
  parameter int T_CAC      = 3,
  parameter int T_RAS      = 10,
  parameter int T_RP       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [RA_BITS-1:0] dram_addr,
  output logic               dram_ras_n,
  output logic               dram_cas_n,
  output logic               dram_we_n,
  output logic               dram_wdata,
  input  logic               dram_rdata,
  output logic               led
);

  localparam int ACC_CLKS = imax(T_ASR + T_RCD + T_ASC + T_CAS + T_RP,
                                 T_ASR + T_RAS + T_RP);

  logic               seq_idle, seq_done, seq_rdata, seq_start;
  op_e                seq_op, t_op;
  logic [RA_BITS-1:0] seq_row, t_row, t_col, ref_row;
  logic               t_req, t_gnt, t_wdata;
  logic               ref_pend, ref_ack;

  always_comb begin
    ref_ack   = seq_idle && ref_pend;
    t_gnt     = seq_idle && !ref_pend && t_req;
    seq_start = ref_ack || t_gnt;
    seq_op    = ref_pend ? OP_REFRESH : t_op;
    seq_row   = ref_pend ? ref_row : t_row;
  end

  dram_refresh_timer #(
    .RA_BITS (RA_BITS),
    .REF_CLKS(REF_CLKS)
  ) u_refresh (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack    (ref_ack),
    .pending(ref_pend),
    .row    (ref_row)
  );

  dram_test_seq #(
    .RA_BITS   (RA_BITS),
    .PAT_LOG   (PAT_LOG),
    .BLINK_CLKS(BLINK_CLKS)
  ) u_test (
    .clk  (clk),
    .rst_n(rst_n),
    .gnt  (t_gnt),
    .done (seq_done),
    .rdata(seq_rdata),
    .req  (t_req),
    .op   (t_op),
    .row  (t_row),
    .col  (t_col),
    .wdata(t_wdata),
    .led  (led)
  );

  dram_strobe_seq #(
    .RA_BITS(RA_BITS),
    .T_ASR  (T_ASR),
    .T_RCD  (T_RCD),
    .T_ASC  (T_ASC),
    .T_CAS  (T_CAS),
    .T_CAC  (T_CAC),
    .T_RAS  (T_RAS),
    .T_RP   (T_RP)
  ) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .op       (seq_op),
    .row      (seq_row),
    .col      (t_col),
    .wdata    (t_wdata),
    .idle     (seq_idle),
    .done     (seq_done),
    .rdata    (seq_rdata),
    .pin_addr (dram_addr),
    .pin_ras_n(dram_ras_n),
    .pin_cas_n(dram_cas_n),
    .pin_we_n (dram_we_n),
    .pin_wdata(dram_wdata),
    .pin_rdata(dram_rdata)
  );

endmodule

// File: rtl/dram_tester_chk.sv
`timescale 1ns/1ps
module dram_tester_chk #(
  parameter int RA_BITS    = 8,
  parameter int BLINK_CLKS = 5000000,
  parameter int REF_BOUND  = 2000
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RA_BITS-1:0] addr,
  input logic               ras_n,
  input logic               cas_n,
  input logic               we_n,
  input logic               led,
  input logic               ref_ack
);

  localparam int OW = $clog2(BLINK_CLKS + 2) + 1;
  localparam int GW = $clog2(REF_BOUND + 2) + 1;

  logic [OW-1:0] off_cnt;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      if (led) off_cnt <= '0;
      else if (off_cnt <= OW'(BLINK_CLKS)) off_cnt <= off_cnt + OW'(1);
      if (ref_ack) gap_cnt <= '0;
      else if (gap_cnt <= GW'(REF_BOUND)) gap_cnt <= gap_cnt + GW'(1);
    end
  end

  a_r1_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(addr));

  a_r2_cas_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (!ras_n && $stable(addr) && $stable(we_n)));

  a_r4_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= GW'(REF_BOUND));

  a_r9_blink_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led) |-> (off_cnt == OW'(BLINK_CLKS)));

  a_r10_led_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (off_cnt > OW'(BLINK_CLKS)) |=> !led);

  a_r10_no_cas_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (off_cnt > OW'(BLINK_CLKS)) |-> cas_n);

endmodule

bind dram_tester dram_tester_chk #(
  .RA_BITS   (RA_BITS),
  .BLINK_CLKS(BLINK_CLKS),
  .REF_BOUND (REF_CLKS + 2 * ACC_CLKS)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .addr   (dram_addr),
  .ras_n  (dram_ras_n),
  .cas_n  (dram_cas_n),
  .we_n   (dram_we_n),
  .led    (led),
  .ref_ack(ref_ack)
);

// File: tb/test_dram_tester.sv
`timescale 1ns/1ps
module test_dram_tester;

  localparam int RA    = 4;
  localparam int AW    = 2 * RA;
  localparam int NLOC  = 1 << AW;
  localparam int ROWS  = 1 << RA;
  localparam int PLOG  = 2;
  localparam int PW    = 1 << PLOG;
  localparam int REF   = 50;
  localparam int BLINK = 20;
  localparam int TASR = 1, TRCD = 2, TASC = 1, TCAS = 3, TCAC = 2, TRAS = 3, TRP = 2;
  localparam int ACC   = TASR + TRCD + TASC + TCAS + TRP;
  localparam int EXP_WR = 2 * AW + 2 * PW * NLOC;
  localparam int EXP_RD = AW + 2 * PW * NLOC;
  localparam int LOGN  = 3 * AW;
  localparam int AF_BIT = 5;
  localparam int CF_LOC = 8'h37;

  logic clk, rst_n;
  logic [RA-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_wdata, dram_rdata, led;

  int nchk, nerr;

  dram_tester #(
    .RA_BITS(RA), .PAT_LOG(PLOG), .REF_CLKS(REF), .BLINK_CLKS(BLINK),
    .T_ASR(TASR), .T_RCD(TRCD), .T_ASC(TASC), .T_CAS(TCAS), .T_CAC(TCAC),
    .T_RAS(TRAS), .T_RP(TRP)
  ) i_dram_tester (
    .clk(clk), .rst_n(rst_n), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_wdata(dram_wdata),
    .dram_rdata(dram_rdata), .led(led)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model and observers, all evaluated on the falling edge
  logic mem [0:NLOC-1];
  int   age [0:ROWS-1];
  logic af_en, cf_en;
  logic prev_ras, prev_cas, prev_led, cas_in_ras;
  logic [RA-1:0] row_l;
  int   eloc, cas_k, ras_low, cyc, last_ref, max_gap, max_age;
  int   nwr, nrd, nref, snap_wr, snap_rd, blinks, off_run, last_off;
  int   cas_w_err, ras_w_err, log_n;
  logic log_we [0:LOGN-1];
  int   log_loc [0:LOGN-1];
  logic log_d [0:LOGN-1];
  logic rd_v;

  initial begin
    prev_ras = 1'b1; prev_cas = 1'b1; prev_led = 1'b1;
    dram_rdata = 1'b0; cyc = 0; eloc = 0; cas_k = 0; ras_low = 0;
    cas_in_ras = 1'b0; row_l = '0;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int r = 0; r < ROWS; r++) begin
      age[r] = age[r] + 1;
      if (age[r] > max_age) max_age = age[r];
    end
    if (!dram_ras_n && prev_ras) begin
      row_l = dram_addr; age[dram_addr] = 0; ras_low = 0; cas_in_ras = 1'b0;
    end
    if (!dram_ras_n) ras_low = ras_low + 1;
    if (dram_ras_n && !prev_ras && !cas_in_ras) begin
      nref = nref + 1;
      if (ras_low != TRAS) ras_w_err = ras_w_err + 1;
      if (last_ref >= 0 && cyc - last_ref > max_gap) max_gap = cyc - last_ref;
      last_ref = cyc;
    end
    if (!dram_cas_n && prev_cas) begin
      cas_in_ras = 1'b1;
      eloc = {row_l, dram_addr};
      if (log_n < LOGN) begin
        log_we[log_n] = !dram_we_n; log_loc[log_n] = eloc; log_d[log_n] = dram_wdata;
        log_n = log_n + 1;
      end
      if (af_en) eloc = eloc & ~(1 << AF_BIT);
      cas_k = 0;
      if (!dram_we_n) begin mem[eloc] = dram_wdata; nwr = nwr + 1; end
      else nrd = nrd + 1;
    end
    if (!dram_cas_n) begin
      rd_v = (cf_en && eloc == CF_LOC) ? 1'b1 : mem[eloc];
      dram_rdata = (cas_k >= TCAC - 1) ? rd_v : ~rd_v;
      cas_k = cas_k + 1;
    end
    if (dram_cas_n && !prev_cas && cas_k != TCAS) cas_w_err = cas_w_err + 1;
    if (!led) off_run = off_run + 1;
    if (!led && prev_led) begin blinks = blinks + 1; snap_wr = nwr; snap_rd = nrd; end
    if (led && !prev_led) begin last_off = off_run; nwr = 0; nrd = 0; log_n = 0; end
    if (led) off_run = 0;
    prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_led = led;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nerr = nerr + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic af, input logic cf);
    @(negedge clk);
    rst_n = 1'b0;
    af_en = af; cf_en = cf;
    nwr = 0; nrd = 0; nref = 0; snap_wr = 0; snap_rd = 0; blinks = 0;
    off_run = 0; last_off = 0; cas_w_err = 0; ras_w_err = 0; log_n = 0;
    last_ref = -1; max_gap = 0; max_age = 0;
    for (int r = 0; r < ROWS; r++) age[r] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cond_blinks(input int n, input int lim);
    int k;
    k = 0;
    while (blinks < n && k < lim) begin @(posedge clk); k++; end
    check(blinks >= n, "R9 loop end reached", blinks, n);
  endtask

  task automatic wait_fail(input int lim);
    int k;
    k = 0;
    while (off_run <= BLINK + 10 && k < lim) begin @(posedge clk); k++; end
    check(off_run > BLINK + 10, "R10 lamp latched dark", off_run, BLINK + 11);
  endtask

  task automatic check_log(input string tag);
    int bad;
    bad = -1;
    for (int i = LOGN - 1; i >= 0; i--) begin
      int b, kind;
      logic ok;
      b = i / 3; kind = i % 3;
      case (kind)
        0: ok = log_we[i] && log_loc[i] == 0 && log_d[i] == 1'b0;
        1: ok = log_we[i] && log_loc[i] == (1 << b) && log_d[i] == 1'b1;
        default: ok = !log_we[i] && log_loc[i] == 0;
      endcase
      if (!ok) bad = i;
    end
    check(bad < 0, tag, bad, -1);
  endtask

  task automatic test_reset;
    rst_n = 1'b0; af_en = 1'b0; cf_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(dram_ras_n === 1'b1, "R11 ras_n in reset", int'(dram_ras_n), 1);
    check(dram_cas_n === 1'b1 && dram_we_n === 1'b1, "R11 cas_n/we_n in reset",
          int'({dram_cas_n, dram_we_n}), 3);
    check(led === 1'b1, "R11 lamp lit in reset", int'(led), 1);
  endtask

  task automatic test_clean_run;
    do_reset(1'b0, 1'b0);
    wait_cond_blinks(1, 60000);
    check(snap_wr == EXP_WR, "R7 writes per loop", snap_wr, EXP_WR);
    check(snap_rd == EXP_RD, "R7 reads per loop", snap_rd, EXP_RD);
    check_log("R1 R5 address test order, first loop");
    wait_cond_blinks(2, 60000);
    check(last_off == BLINK, "R9 dark time of blink", last_off, BLINK);
    check(snap_wr == EXP_WR && snap_rd == EXP_RD, "R9 second loop complete", snap_rd, EXP_RD);
    check_log("R9 R5 second loop restarts with address test");
    check(cas_w_err == 0, "R2 CAS low width", cas_w_err, 0);
    check(ras_w_err == 0, "R3 refresh RAS width", ras_w_err, 0);
    check(nref >= 2 * ROWS, "R3 refresh count", nref, 2 * ROWS);
    check(max_age <= ROWS * REF + ACC + 2, "R3 row retention", max_age, ROWS * REF + ACC + 2);
    check(max_gap <= REF + ACC + 2, "R4 refresh spacing", max_gap, REF + ACC + 2);
  endtask

  task automatic test_addr_fault;
    int acc, nr0;
    do_reset(1'b1, 1'b0);
    wait_fail(3000);
    check(nrd == AF_BIT + 1, "R6 failing read index", nrd, AF_BIT + 1);
    check(nwr == 2 * (AF_BIT + 1), "R6 no cell-test writes", nwr, 2 * (AF_BIT + 1));
    acc = nwr + nrd; nr0 = nref;
    repeat (1500) @(posedge clk);
    check(nwr + nrd == acc, "R10 no CAS after failure", nwr + nrd, acc);
    check(nref > nr0, "R10 refresh continues", nref, nr0 + 1);
    check(led === 1'b0, "R10 lamp stays dark", int'(led), 0);
  endtask

  task automatic test_cell_fault;
    do_reset(1'b0, 1'b1);
    wait_fail(8000);
    check(nrd == AW + CF_LOC + 1, "R8 failing cell read", nrd, AW + CF_LOC + 1);
    check(nwr == 2 * AW + NLOC, "R8 R7 full write before read", nwr, 2 * AW + NLOC);
    repeat (500) @(posedge clk);
    check(led === 1'b0, "R10 lamp dark after cell fault", int'(led), 0);
  endtask

  initial begin
    #(190000 * 10);
    nchk = nchk + 1; nerr = nerr + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0;
    test_reset();
    test_clean_run();
    test_addr_fault();
    test_cell_fault();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule